// File: doc/BRIEF.md
# Headset Jack Detect Controller

This block turns the two outputs of a window comparator on a headset sense line into a clean, debounced three-state level. The two outputs are "above the upper threshold" and "below the lower threshold". The upper threshold sits at 95% of the bias reference and the lower one at 10%. The block reports that level in a 2-bit status field. Each accepted change of level raises a sticky change flag, and an active-low interrupt follows that flag. The host clears the flag with a one-cycle read-clear strobe.

Timing comes from a one-cycle millisecond tick. A new level must stay unbroken for 25, 50, 100 or 200 ticks before the status takes it. Any other raw level seen during the wait restarts the count. A return to the current status cancels the wait.

An event machine watches the sequence of accepted levels. It reports four events: insertion with a microphone, insertion of a stereo headset, a button press and removal. Each event comes out as a 3-bit code with a one-cycle valid pulse.

The debounce machine has two states:
- `DB_SETTLED`: the raw level equals the status.
- `DB_TIMING`: a different level is being timed. Its transitions are start, cancel, restart and accept.

The event machine has four states: `EV_S_EMPTY`, `EV_S_MIC`, `EV_S_BTN_DOWN` and `EV_S_STEREO`. It moves between them on accepted levels:

| From | Accepted level | To | Event |
|---|---|---|---|
| `EV_S_EMPTY` | mid | `EV_S_MIC` | insertion with microphone |
| `EV_S_EMPTY` | low | `EV_S_STEREO` | stereo insertion |
| `EV_S_MIC` | low | `EV_S_BTN_DOWN` | none |
| `EV_S_BTN_DOWN` | mid | `EV_S_MIC` | button press |
| `EV_S_STEREO` | mid | `EV_S_MIC` | none |
| any state | high | `EV_S_EMPTY` | removal |

Top module: `jack_detect_ctrl`

## Requirements
- R1: The raw level is decoded with a fixed priority. `above_hi` high gives 2'b10 (high). Otherwise `below_lo` high gives 2'b00 (low). Otherwise the level is 2'b01 (mid). `sense_status` never shows 2'b11.
- R2: `deb_sel` sets the debounce length in ticks: 2'b00 gives 25, 2'b01 gives 50, 2'b10 gives 100 and 2'b11 gives 200.
- R3: A raw level that differs from the status is timed. Ticks are counted from the clock edge after the edge where the level first appears. The status takes the new level on the edge that samples the Nth counted tick. A different raw level restarts the count. A return to the status level cancels it. A glitch shorter than N ticks leaves the status unchanged.
- R4: Reset puts the block in its idle state: status 2'b10, flag 0, `irq_n` 1, no event. While `det_enable` is low, the block returns to that idle state on the next edge and stays there whatever the comparator inputs do.
- R5: An accepted change sets `change_flag` on the same edge that updates the status. `irq_n` is always the inverse of `change_flag`.
- R6: With no accepted change on that edge, `status_clr` clears `change_flag` on the next edge. When an accept and a clear fall on the same edge, the flag stays set.
- R7: Accepting mid from high gives `evt_code` 1 (insertion with microphone). Accepting low from high gives `evt_code` 2 (stereo insertion).
- R8: The accepted sequence mid, low, mid gives `evt_code` 3 (button press) on the return to mid. The step to low gives no event.
- R9: Accepting high from low or mid gives `evt_code` 4 (removal), and the status then reads 2'b10.
- R10: `evt_valid` is high for exactly one cycle, together with the status change that completes the event. It is never high with code 0. Accepting mid after a stereo insertion gives no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_enable | input | 1 | Detection enable |
| ms_tick | input | 1 | One-cycle millisecond tick |
| deb_sel | input | 2 | Debounce length select |
| above_hi | input | 1 | Comparator: sense line above upper threshold |
| below_lo | input | 1 | Comparator: sense line below lower threshold |
| status_clr | input | 1 | Host read-clear strobe for the change flag |
| sense_status | output | 2 | Debounced level (00 low, 01 mid, 10 high) |
| change_flag | output | 1 | Sticky change flag |
| irq_n | output | 1 | Active-low interrupt request |
| evt_valid | output | 1 | One-cycle event valid |
| evt_code | output | 3 | Event code (1 mic insert, 2 stereo insert, 3 button, 4 removal) |

## Verification
The status, the flag, `irq_n` and the event outputs all change on the clock edge that samples the Nth counted tick. They are visible one half cycle later. A clear or a disable shows on the edge after the strobe is sampled. The bench drives inputs on falling edges and steps a behavioural model on each rising edge. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed checks wait for an exact number of ticks. They confirm that the status still holds its old value after N-1 ticks and holds the new value right after the Nth.

// File: rtl/jd_pkg.sv
package jd_pkg;
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } level_e;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_INS_MIC    = 3'd1,
        EV_INS_STEREO = 3'd2,
        EV_BUTTON     = 3'd3,
        EV_REMOVE     = 3'd4
    } event_e;
endpackage

// File: rtl/jd_level_decode.sv
module jd_level_decode
    import jd_pkg::*;
(
    input  logic   above_hi,
    input  logic   below_lo,
    output level_e lvl
);
    // Upper comparator has priority (R1)
    always_comb begin
        if (above_hi)      lvl = LVL_HIGH;
        else if (below_lo) lvl = LVL_LOW;
        else               lvl = LVL_MID;
    end
endmodule

// File: rtl/jd_debounce.sv
module jd_debounce
    import jd_pkg::*;
#(
    parameter int unsigned DEB_T0 = 25,
    parameter int unsigned DEB_T1 = 50,
    parameter int unsigned DEB_T2 = 100,
    parameter int unsigned DEB_T3 = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tick,
    input  logic [1:0] sel,
    input  level_e     raw,
    output level_e     stable,
    output level_e     cand,
    output logic       accept
);
    localparam int unsigned MAX01  = (DEB_T0 > DEB_T1) ? DEB_T0 : DEB_T1;
    localparam int unsigned MAX23  = (DEB_T2 > DEB_T3) ? DEB_T2 : DEB_T3;
    localparam int unsigned DEB_MX = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned CNT_W  = $clog2(DEB_MX + 1);

    typedef enum logic {DB_SETTLED, DB_TIMING} db_state_e;

    db_state_e        st_q, st_d;
    level_e           cand_q, cand_d;
    level_e           stable_q, stable_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;
    logic             acc;

    always_comb begin
        unique case (sel)
            2'b00: lim = CNT_W'(DEB_T0);
            2'b01: lim = CNT_W'(DEB_T1);
            2'b10: lim = CNT_W'(DEB_T2);
            2'b11: lim = CNT_W'(DEB_T3);
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d     = st_q;
        cand_d   = cand_q;
        stable_d = stable_q;
        cnt_d    = cnt_q;
        acc      = 1'b0;
        unique case (st_q)
            DB_SETTLED: begin
                if (raw != stable_q) begin          // start
                    st_d   = DB_TIMING;
                    cand_d = raw;
                    cnt_d  = '0;
                end
            end
            DB_TIMING: begin
                if (raw == stable_q) begin          // cancel
                    st_d  = DB_SETTLED;
                    cnt_d = '0;
                end else if (raw != cand_q) begin   // restart
                    cand_d = raw;
                    cnt_d  = '0;
                end else if (tick) begin
                    if (cnt_q == lim - CNT_W'(1)) begin  // accept
                        acc      = 1'b1;
                        stable_d = cand_q;
                        st_d     = DB_SETTLED;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= DB_SETTLED;
            cand_q   <= LVL_HIGH;
            stable_q <= LVL_HIGH;
            cnt_q    <= '0;
        end else if (!enable) begin
            st_q     <= DB_SETTLED;
            cand_q   <= LVL_HIGH;
            stable_q <= LVL_HIGH;
            cnt_q    <= '0;
        end else begin
            st_q     <= st_d;
            cand_q   <= cand_d;
            stable_q <= stable_d;
            cnt_q    <= cnt_d;
        end
    end

    assign stable = stable_q;
    assign cand   = cand_q;
    assign accept = acc & enable;

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stable_q != 2'b11);

    assert_update_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && stable_q != $past(stable_q)) |-> $past(tick));

    assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (stable_q == LVL_HIGH && st_q == DB_SETTLED));
endmodule

// File: rtl/jd_event_fsm.sv
module jd_event_fsm
    import jd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       accept,
    input  level_e     new_lvl,
    output logic       evt_valid,
    output logic [2:0] evt_code
);
    typedef enum logic [1:0] {
        EV_S_EMPTY,
        EV_S_MIC,
        EV_S_BTN_DOWN,
        EV_S_STEREO
    } ev_state_e;

    ev_state_e st_q, st_d;
    event_e    ev_d;
    event_e    ev_q;
    logic      vld_q;

    // Next-state and event decode
    always_comb begin
        st_d = st_q;
        ev_d = EV_NONE;
        if (accept) begin
            if (new_lvl == LVL_HIGH) begin
                st_d = EV_S_EMPTY;
                ev_d = EV_REMOVE;
            end else begin
                unique case (st_q)
                    EV_S_EMPTY: begin
                        if (new_lvl == LVL_MID) begin
                            st_d = EV_S_MIC;
                            ev_d = EV_INS_MIC;
                        end else begin
                            st_d = EV_S_STEREO;
                            ev_d = EV_INS_STEREO;
                        end
                    end
                    EV_S_MIC: begin
                        if (new_lvl == LVL_LOW) st_d = EV_S_BTN_DOWN;
                    end
                    EV_S_BTN_DOWN: begin
                        if (new_lvl == LVL_MID) begin
                            st_d = EV_S_MIC;
                            ev_d = EV_BUTTON;
                        end
                    end
                    EV_S_STEREO: begin
                        if (new_lvl == LVL_MID) st_d = EV_S_MIC;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st_q <= EV_S_EMPTY;
        else if (!enable) st_q <= EV_S_EMPTY;
        else              st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            ev_q  <= EV_NONE;
        end else if (!enable) begin
            vld_q <= 1'b0;
            ev_q  <= EV_NONE;
        end else begin
            vld_q <= (ev_d != EV_NONE);
            ev_q  <= ev_d;
        end
    end

    assign evt_valid = vld_q;
    assign evt_code  = ev_q;

    assert_event_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> ev_q != EV_NONE);

    assert_event_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    assert_removal_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && ev_q == EV_REMOVE) |-> st_q == EV_S_EMPTY);
endmodule

// File: rtl/jack_detect_ctrl.sv
module jack_detect_ctrl
    import jd_pkg::*;
#(
    parameter int unsigned DEB_T0 = 25,
    parameter int unsigned DEB_T1 = 50,
    parameter int unsigned DEB_T2 = 100,
    parameter int unsigned DEB_T3 = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det_enable,
    input  logic       ms_tick,
    input  logic [1:0] deb_sel,
    input  logic       above_hi,
    input  logic       below_lo,
    input  logic       status_clr,
    output logic [1:0] sense_status,
    output logic       change_flag,
    output logic       irq_n,
    output logic       evt_valid,
    output logic [2:0] evt_code
);
    level_e raw_lvl;
    level_e stable_lvl;
    level_e cand_lvl;
    logic   accept;
    logic   flag_q;

    jd_level_decode u_dec (
        .above_hi (above_hi),
        .below_lo (below_lo),
        .lvl      (raw_lvl)
    );

    jd_debounce #(
        .DEB_T0 (DEB_T0),
        .DEB_T1 (DEB_T1),
        .DEB_T2 (DEB_T2),
        .DEB_T3 (DEB_T3)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (det_enable),
        .tick   (ms_tick),
        .sel    (deb_sel),
        .raw    (raw_lvl),
        .stable (stable_lvl),
        .cand   (cand_lvl),
        .accept (accept)
    );

    jd_event_fsm u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (det_enable),
        .accept    (accept),
        .new_lvl   (cand_lvl),
        .evt_valid (evt_valid),
        .evt_code  (evt_code)
    );

    // Sticky change flag: a new change beats a coincident clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!det_enable) flag_q <= 1'b0;
        else if (accept)     flag_q <= 1'b1;
        else if (status_clr) flag_q <= 1'b0;
    end

    assign sense_status = stable_lvl;
    assign change_flag  = flag_q;
    assign irq_n        = ~flag_q;

    assert_flag_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(det_enable) && $past(accept)) |-> (change_flag && !irq_n));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_clr) && !$past(accept)) |-> !change_flag);

    assert_flag_rise_with_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(change_flag) |-> sense_status != $past(sense_status));

    assert_event_with_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> sense_status != $past(sense_status));
endmodule

// File: tb/jack_detect_ctrl_tb.sv
module jack_detect_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_enable = 1'b0;
    logic       ms_tick = 1'b0;
    logic [1:0] deb_sel = 2'b00;
    logic       above_hi = 1'b1;
    logic       below_lo = 1'b0;
    logic       status_clr = 1'b0;
    logic [1:0] sense_status;
    logic       change_flag;
    logic       irq_n;
    logic       evt_valid;
    logic [2:0] evt_code;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit tick_run = 1'b0;
    int tick_div = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // model state
    int m_st = 2, m_cd = 2, m_ticks = 0, m_fl = 0, m_prev2 = 2;
    bit m_pend = 0, m_evv = 0;
    int m_ev = 0;
    int got_q[$];

    always #10 clk = ~clk;   // 50 MHz

    jack_detect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .det_enable(det_enable), .ms_tick(ms_tick),
        .deb_sel(deb_sel), .above_hi(above_hi), .below_lo(below_lo),
        .status_clr(status_clr), .sense_status(sense_status),
        .change_flag(change_flag), .irq_n(irq_n),
        .evt_valid(evt_valid), .evt_code(evt_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b00: return 25;
            2'b01: return 50;
            2'b10: return 100;
            default: return 200;
        endcase
    endfunction

    // tick generator: one tick every four cycles
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        ms_tick = tick_run && (tick_div == 0);
    end

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        int raw;
        raw = above_hi ? 2 : (below_lo ? 0 : 1);
        m_evv = 0;
        m_ev = 0;
        if (!rst_n || !det_enable) begin
            m_st = 2; m_cd = 2; m_pend = 0; m_ticks = 0; m_fl = 0; m_prev2 = 2;
        end else begin
            bit acc;
            acc = 0;
            if (raw == m_st) m_pend = 0;
            else if (!m_pend || raw != m_cd) begin
                m_pend = 1; m_cd = raw; m_ticks = 0;
            end else if (ms_tick) begin
                m_ticks++;
                if (m_ticks >= lim_of(deb_sel)) acc = 1;
            end
            if (acc) begin
                if (m_cd == 2) m_ev = 4;
                else if (m_st == 2) m_ev = (m_cd == 1) ? 1 : 2;
                else if (m_cd == 1 && m_st == 0 && m_prev2 == 1) m_ev = 3;
                m_evv = (m_ev != 0);
                m_prev2 = m_st;
                m_st = m_cd;
                m_pend = 0;
                m_fl = 1;
            end else if (status_clr) m_fl = 0;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(sense_status == 2'(m_st), "R3", "status", sense_status, m_st);
            check(change_flag == m_fl[0], "R5", "flag", change_flag, m_fl);
            check(irq_n == !m_fl[0], "R5", "irq_n", irq_n, !m_fl[0]);
            check(evt_valid == m_evv, "R10", "evt_valid", evt_valid, m_evv);
            if (m_evv) check(evt_code == 3'(m_ev), "R7", "evt_code", evt_code, m_ev);
            if (evt_valid) got_q.push_back(int'(evt_code));
        end
    end

    task automatic set_lvl(input int l);
        @(negedge clk);
        above_hi = (l == 2);
        below_lo = (l == 0);
    endtask

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            @(posedge clk);
            if (ms_tick) seen++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int exp_ev[5] = '{1, 3, 4, 2, 2};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: idle after reset
        check(sense_status == 2'b10 && change_flag == 0 && irq_n == 1 && evt_valid == 0,
              "R4", "reset idle", sense_status, 2);
        cmp_on = 1'b1;
        det_enable = 1'b1;
        tick_run = 1'b1;
        repeat (8) @(negedge clk);

        // R1: both comparators high decodes as high -> no change
        below_lo = 1'b1;
        wait_ticks(30);
        check(sense_status == 2'b10, "R1", "priority high", sense_status, 2);
        set_lvl(2);

        // R3: glitch shorter than 25 ticks
        set_lvl(1);
        wait_ticks(10);
        set_lvl(2);
        wait_ticks(40);
        check(sense_status == 2'b10 && change_flag == 0, "R3", "glitch ignored", sense_status, 2);

        // R3: restart on different level
        set_lvl(1);
        wait_ticks(20);
        set_lvl(0);
        set_lvl(1);
        wait_ticks(20);
        check(sense_status == 2'b10, "R3", "restart count", sense_status, 2);
        wait_ticks(10);
        // R7: mic insertion reached
        check(sense_status == 2'b01, "R7", "mid accepted", sense_status, 1);
        check(change_flag == 1 && irq_n == 0, "R5", "flag after change", change_flag, 1);

        // R6: clear
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        check(change_flag == 0 && irq_n == 1, "R6", "flag cleared", change_flag, 0);

        // R2 with sel 00: exact tick count, then R8 button
        set_lvl(0);
        wait_ticks(24);
        check(sense_status == 2'b01, "R2", "25-tick hold old", sense_status, 1);
        wait_ticks(1);
        check(sense_status == 2'b00, "R2", "25-tick new", sense_status, 0);
        set_lvl(1);
        wait_ticks(25);
        check(sense_status == 2'b01, "R8", "button return", sense_status, 1);

        // R2 sel 01, R9 removal
        deb_sel = 2'b01;
        set_lvl(2);
        wait_ticks(49);
        check(sense_status == 2'b01, "R2", "50-tick hold old", sense_status, 1);
        wait_ticks(1);
        check(sense_status == 2'b10, "R9", "removal high", sense_status, 2);

        // R2 sel 11: stereo insertion
        deb_sel = 2'b11;
        set_lvl(0);
        wait_ticks(199);
        check(sense_status == 2'b10, "R2", "200-tick hold old", sense_status, 2);
        wait_ticks(1);
        check(sense_status == 2'b00, "R7", "stereo low", sense_status, 0);

        // R10: stereo -> mid gives no event (sel 10)
        deb_sel = 2'b10;
        set_lvl(1);
        wait_ticks(100);
        check(sense_status == 2'b01 && evt_valid == 0, "R10", "no event stereo->mid", evt_valid, 0);

        // R4: disable
        det_enable = 1'b0;
        @(negedge clk);
        check(sense_status == 2'b10 && change_flag == 0 && irq_n == 1, "R4", "disable idle",
              sense_status, 2);
        set_lvl(0);
        deb_sel = 2'b00;
        wait_ticks(60);
        check(sense_status == 2'b10 && change_flag == 0 && got_q.size() == 4, "R4",
              "disabled no update", sense_status, 2);

        // R6: clear coincident with accept
        det_enable = 1'b1;
        status_clr = 1'b1;
        wait_ticks(25);
        check(change_flag == 1, "R6", "accept beats clear", change_flag, 1);
        @(negedge clk);
        check(change_flag == 0 && irq_n == 1, "R6", "clear next cycle", change_flag, 0);
        status_clr = 1'b0;
        repeat (4) @(negedge clk);

        // event log
        check(got_q.size() == 5, "R10", "event count", got_q.size(), 5);
        for (int i = 0; i < 5; i++)
            if (i < got_q.size())
                check(got_q[i] == exp_ev[i], "R8", "event order", got_q[i], exp_ev[i]);
        finish_run();
    end
endmodule